// File: doc/BRIEF.md
# Bit-Serial Lookup-Table Inner Product Unit

This block forms the dot product of a fixed set of signed coefficients with a vector of two's-complement samples and uses no multiplier. It captures the whole sample vector in one cycle. It then works through the samples one bit position at a time, starting with the least significant bit. At each bit position it collects the bit of that weight from every sample into an address. That address selects a precomputed partial sum of the coefficients, and the partial sum is folded into a shifting accumulator.

The coefficient table is computed from a parameter when the design is elaborated. Entry `k` is the sum of the coefficients whose tap index is a set bit of `k`. The most significant bit of a sample carries a negative weight, so the table word for that bit position is subtracted instead of added. The block is meant to be instanced as one output lane of a small transform or filter, for example one row of an 8-point cosine transform. A new vector is offered with `start`. The answer appears on `result` together with a one-cycle `done` strobe, and it stays there until the next accepted vector.

Top module: `da_inner_product`

## Requirements
- R1: While reset is asserted and directly after it, `busy` and `done` are 0 and `result` is 0.
- R2: `result` equals the exact signed sum over j of c_j·x_j, as a two's-complement number of COEF_W+clog2(NUM_TAPS)+SAMPLE_W bits. Sample j is `sampleIn[j*SAMPLE_W +: SAMPLE_W]` and coefficient j is `COEFS[j*COEF_W +: COEF_W]`, and both are signed.
- R3: A vector is accepted on a rising clock edge where `start` is 1 and `busy` is 0. `done` is 1 for exactly one cycle, which begins at the SAMPLE_W-th rising edge after the accepting edge.
- R4: `busy` is 1 in each of the SAMPLE_W cycles that follow the accepting edge. It is 0 again in the cycle in which `done` is 1.
- R5: While `busy` is 1, `start` is ignored and changes on `sampleIn` do not affect the result that is in progress.
- R6: `result` holds its value from the `done` cycle until the next vector is accepted.
- R7: Bit j of the table address comes from sample j, and table entry k is the sum of c_j over the set bits j of k. A vector whose only non-zero sample is x_j = 1 gives c_j, and a vector whose only non-zero sample is x_j = -1 gives -c_j.
- R8: The sign bit position has weight -2^(SAMPLE_W-1). With every sample equal to -2^(SAMPLE_W-1), the result is -2^(SAMPLE_W-1)·Σc_j.
- R9: No overflow occurs for extreme vectors, where each sample is the most positive or most negative value chosen to match the sign of its coefficient, or all samples are at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Offers the vector on `sampleIn`; taken only when idle |
| sampleIn | input | NUM_TAPS*SAMPLE_W | Packed signed samples, tap j at bits j*SAMPLE_W upward |
| busy | output | 1 | A vector is being processed |
| done | output | 1 | One-cycle strobe: `result` is valid |
| result | output | COEF_W+clog2(NUM_TAPS)+SAMPLE_W | Signed inner product, held until the next accepted vector |

## Verification
The bench drives each vector at a falling edge, so the accepting edge is the next rising edge. It then samples at falling edges. `busy` must be 1 at the first falling edge after acceptance. `done` must stay 0 through the next SAMPLE_W-1 falling edges. `done` and the correct `result` must both be present at the falling edge that follows the SAMPLE_W-th rising edge, and one falling edge later `done` must be 0 again with `result` unchanged. A few runs raise `start` again and corrupt `sampleIn` partway through a computation. These runs must keep exactly the same latency and result.

// File: rtl/da_pkg.sv
package da_pkg;

  // Strobes issued by the sequencer to the arithmetic path each cycle.
  typedef struct packed {
    logic load;       // capture a new sample vector and clear the accumulator
    logic step;       // consume one bit plane
    logic lastPlane;  // the plane being consumed is the sign plane
  } daCtrl_t;

endpackage

// File: rtl/da_lut.sv
module da_lut #(
  parameter int NUM_TAPS = 8,
  parameter int COEF_W   = 8,
  parameter int LUT_W    = COEF_W + $clog2(NUM_TAPS),
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic [NUM_TAPS-1:0]     addr,
  output logic signed [LUT_W-1:0] word
);

  localparam int DEPTH = 2 ** NUM_TAPS;

  // Partial sum of the coefficients selected by the set bits of k.
  function automatic logic signed [LUT_W-1:0] entryOf(input logic [NUM_TAPS-1:0] k);
    logic signed [LUT_W-1:0]  acc;
    logic signed [COEF_W-1:0] c;
    acc = '0;
    for (int j = 0; j < NUM_TAPS; j++) begin
      c = COEFS[j*COEF_W +: COEF_W];
      if (k[j]) acc = acc + LUT_W'(c);
    end
    return acc;
  endfunction

  logic signed [LUT_W-1:0] lutTable [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    assign lutTable[k] = entryOf(NUM_TAPS'(k));
  end

  assign word = lutTable[addr];

endmodule

// File: rtl/da_ctrl.sv
module da_ctrl
  import da_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output daCtrl_t ctrl,
  output logic    busy,
  output logic    done
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

  logic             busyR;
  logic             doneR;
  logic [CNT_W-1:0] planeCnt;

  always_comb begin
    ctrl.load      = start && !busyR;
    ctrl.step      = busyR;
    ctrl.lastPlane = busyR && (planeCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR    <= 1'b0;
      doneR    <= 1'b0;
      planeCnt <= '0;
    end else begin
      doneR <= ctrl.lastPlane;
      if (ctrl.load) begin
        busyR    <= 1'b1;
        planeCnt <= '0;
      end else if (busyR) begin
        if (ctrl.lastPlane) busyR <= 1'b0;
        planeCnt <= planeCnt + 1'b1;
      end
    end
  end

  assign busy = busyR;
  assign done = doneR;

endmodule

// File: rtl/da_datapath.sv
module da_datapath
  import da_pkg::*;
#(
  parameter int NUM_TAPS = 8,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0,
  parameter int LUT_W    = COEF_W + $clog2(NUM_TAPS),
  parameter int RES_W    = LUT_W + SAMPLE_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  daCtrl_t                      ctrl,
  input  logic [NUM_TAPS*SAMPLE_W-1:0] sampleIn,
  output logic [RES_W-1:0]             result
);

  logic [SAMPLE_W-1:0]     smpReg [NUM_TAPS];
  logic [NUM_TAPS-1:0]     planeAddr;
  logic signed [LUT_W-1:0] lutWord;
  logic signed [LUT_W-1:0] accHi;
  logic [SAMPLE_W-1:0]     accLo;
  logic signed [LUT_W:0]   hiExt;
  logic signed [LUT_W:0]   wordExt;
  logic signed [LUT_W:0]   stepSum;

  // One right-shifting register per tap; bit 0 is that tap's current plane bit.
  for (genvar j = 0; j < NUM_TAPS; j++) begin : g_tap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          smpReg[j] <= '0;
      else if (ctrl.load) smpReg[j] <= sampleIn[j*SAMPLE_W +: SAMPLE_W];
      else if (ctrl.step) smpReg[j] <= smpReg[j] >> 1;
    end
    assign planeAddr[j] = smpReg[j][0];
  end

  da_lut #(
    .NUM_TAPS(NUM_TAPS),
    .COEF_W  (COEF_W),
    .LUT_W   (LUT_W),
    .COEFS   (COEFS)
  ) lutInst (
    .addr(planeAddr),
    .word(lutWord)
  );

  // Add the plane's partial sum (subtract on the sign plane), then halve.
  always_comb begin
    hiExt   = {accHi[LUT_W-1], accHi};
    wordExt = {lutWord[LUT_W-1], lutWord};
    stepSum = ctrl.lastPlane ? (hiExt - wordExt) : (hiExt + wordExt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accHi <= '0;
      accLo <= '0;
    end else if (ctrl.load) begin
      accHi <= '0;
      accLo <= '0;
    end else if (ctrl.step) begin
      accHi <= stepSum[LUT_W:1];
      accLo <= {stepSum[0], accLo[SAMPLE_W-1:1]};
    end
  end

  assign result = {accHi, accLo};

endmodule

// File: rtl/da_inner_product.sv
module da_inner_product
  import da_pkg::*;
#(
  parameter int NUM_TAPS = 8,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS =
    {8'hFF, 8'h03, 8'hEE, 8'h32, 8'hB5, 8'h59, 8'h80, 8'h7F}
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic                                          start,
  input  logic [NUM_TAPS*SAMPLE_W-1:0]                  sampleIn,
  output logic                                          busy,
  output logic                                          done,
  output logic [COEF_W+$clog2(NUM_TAPS)+SAMPLE_W-1:0]   result
);

  localparam int LUT_W = COEF_W + $clog2(NUM_TAPS);
  localparam int RES_W = LUT_W + SAMPLE_W;

  daCtrl_t ctrlBus;

  da_ctrl #(
    .SAMPLE_W(SAMPLE_W)
  ) ctrlInst (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrlBus),
    .busy (busy),
    .done (done)
  );

  da_datapath #(
    .NUM_TAPS(NUM_TAPS),
    .SAMPLE_W(SAMPLE_W),
    .COEF_W  (COEF_W),
    .COEFS   (COEFS),
    .LUT_W   (LUT_W),
    .RES_W   (RES_W)
  ) dpInst (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrlBus),
    .sampleIn(sampleIn),
    .result  (result)
  );

endmodule

// File: rtl/da_inner_product_chk.sv
module da_inner_product_chk #(
  parameter int SAMPLE_W = 8,
  parameter int RES_W    = 19
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1) + 1;

  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == CNT_W'(SAMPLE_W)));

  // R4
  busy_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R4
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R5
  busy_continue_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(result));

endmodule

bind da_inner_product da_inner_product_chk #(
  .SAMPLE_W(SAMPLE_W),
  .RES_W   (COEF_W + $clog2(NUM_TAPS) + SAMPLE_W)
) chkInst (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .result(result)
);

// File: tb/da_inner_product_test.sv
`timescale 1ns/1ps
module da_inner_product_test;

  localparam int N     = 8;
  localparam int W     = 8;
  localparam int CW    = 8;
  localparam int RES_W = CW + $clog2(N) + W;
  localparam logic [N*CW-1:0] COEFS =
    {8'hFF, 8'h03, 8'hEE, 8'h32, 8'hB5, 8'h59, 8'h80, 8'h7F};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [N*W-1:0]   sampleIn = '0;
  logic             busy;
  logic             done;
  logic [RES_W-1:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  da_inner_product #(
    .NUM_TAPS(N), .SAMPLE_W(W), .COEF_W(CW), .COEFS(COEFS)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .sampleIn(sampleIn),
    .busy(busy), .done(done), .result(result)
  );

  function automatic longint coefOf(input int j);
    logic signed [CW-1:0] c;
    c = COEFS[j*CW +: CW];
    return longint'(c);
  endfunction

  function automatic longint modelDot(input logic [N*W-1:0] v);
    longint s;
    logic signed [W-1:0] x;
    s = 0;
    for (int j = 0; j < N; j++) begin
      x = v[j*W +: W];
      s = s + coefOf(j) * longint'(x);
    end
    return s;
  endfunction

  function automatic longint resVal();
    logic signed [RES_W-1:0] r;
    r = result;
    return longint'(r);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Offer one vector and check the whole timing and result window.
  task automatic runVec(input logic [N*W-1:0] v, input bit disturb, input string tag);
    longint exp;
    longint held;
    exp = modelDot(v);
    @(negedge clk);
    sampleIn = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R4 busy after accept", longint'(busy), 1);
    check(done == 1'b0, "R3 done early", longint'(done), 0);
    for (int k = 1; k <= W; k++) begin
      if (disturb && k == 2) begin
        start = 1'b1;
        sampleIn = ~v;
      end
      if (disturb && k == 3) start = 1'b0;
      @(negedge clk);
      if (k < W) begin
        check(done == 1'b0, "R3 done early", longint'(done), 0);
      end else begin
        check(done == 1'b1, "R3 done latency", longint'(done), 1);
        check(busy == 1'b0, "R4 busy cleared", longint'(busy), 0);
        check(resVal() == exp, tag, resVal(), exp);
      end
    end
    held = resVal();
    sampleIn = '0;
    @(negedge clk);
    check(done == 1'b0, "R3 done pulse width", longint'(done), 0);
    check(resVal() == held, "R6 result hold", resVal(), held);
  endtask

  function automatic logic [N*W-1:0] randVec();
    logic [N*W-1:0] v;
    for (int j = 0; j < N; j++) v[j*W +: W] = W'($urandom);
    return v;
  endfunction

  initial begin
    logic [N*W-1:0] v;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset flags", longint'({busy, done}), 0);
    check(result == '0, "R1 reset result", resVal(), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 after reset",
          longint'({busy, done}), 0);

    // R7: single unit samples pick out single coefficients
    for (int j = 0; j < N; j++) begin
      v = '0; v[j*W +: W] = W'(1);
      runVec(v, 1'b0, "R7 unit +1");
      v = '0; v[j*W +: W] = '1;
      runVec(v, 1'b0, "R7 unit -1");
    end

    // R8: sign plane weight
    v = '0;
    for (int j = 0; j < N; j++) v[j*W +: W] = {1'b1, {(W-1){1'b0}}};
    runVec(v, 1'b0, "R8 all most-negative");
    for (int j = 0; j < N; j++) begin
      v = '0; v[j*W +: W] = {1'b1, {(W-1){1'b0}}};
      runVec(v, 1'b0, "R8 single most-negative");
    end

    // R9: extreme vectors
    for (int j = 0; j < N; j++)
      v[j*W +: W] = (coefOf(j) >= 0) ? {1'b0, {(W-1){1'b1}}} : {1'b1, {(W-1){1'b0}}};
    runVec(v, 1'b0, "R9 max positive");
    runVec(~v, 1'b0, "R9 near min");
    for (int j = 0; j < N; j++)
      v[j*W +: W] = (coefOf(j) >= 0) ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    runVec(v, 1'b0, "R9 max negative");
    for (int j = 0; j < N; j++) v[j*W +: W] = {1'b0, {(W-1){1'b1}}};
    runVec(v, 1'b0, "R9 all most-positive");

    // R2: full sweep of one tap, random remainder
    for (int s = 0; s < (1 << W); s++) begin
      v = randVec();
      v[3*W +: W] = W'(s);
      runVec(v, 1'b0, "R2 tap sweep");
    end
    for (int i = 0; i < 300; i++) runVec(randVec(), 1'b0, "R2 random");

    // R5: start and sample changes mid-computation are ignored
    for (int i = 0; i < 20; i++) runVec(randVec(), 1'b1, "R5 disturbed run");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule